// File: doc/BRIEF.md
# Double-Buffered Palette Frame Store

This block keeps two complete frames of 8-bit colour indices in on-chip memory. Each frame has its own dual-port RAM, so the processor and the display never stall each other. The processor writes pixels into whichever frame is not being shown, the back frame. It addresses a pixel by its linear byte offset, row times width plus column. The display side supplies one enable per pixel. On each enable the block reads the next pixel of the shown frame, the front frame, in raster order. It then expands the index through a 256-entry palette into three 6-bit colour channels.

A swap request exchanges the front and back roles. The exchange happens only when the raster wraps from the last pixel of a frame back to pixel 0, so a frame is never shown half from one buffer and half from the other. Software finishes a frame, requests a swap, and then watches the status outputs. Frame size is set by parameters: 320x200 in the target chip, and smaller by default so that it builds quickly.

The palette is written through a two-register pair. One register sets the entry pointer. The other register writes an entry and then steps the pointer forward.

Top module: `pal_fb_dbuf`

## Requirements
- R1: After reset, buffer 0 is the front frame (`front_o`=0), `swap_pend_o`=0, `swap_done_o`=0 and `pix_valid_o`=0. Every palette entry reads as zero, so any scanned pixel gives red=green=blue=0.
- R2: A pixel write with `wr_en_i`=1 stores `wr_data_i` at linear offset `wr_addr_i` (y*H_PIX+x) of the back frame, which is the frame not selected by `front_o`.
- R3: A pixel write with `wr_addr_i` >= H_PIX*V_LINES is dropped and changes no stored pixel.
- R4: Each cycle with `scan_en_i`=1 reads the current raster offset and then advances it by one. After offset H_PIX*V_LINES-1 the offset wraps to 0. With `scan_en_i`=0 the offset holds.
- R5: The colour for a pixel enabled in cycle t appears on `red_o`/`green_o`/`blue_o` with `pix_valid_o`=1 in cycle t+2: one cycle for the frame read and one for the palette. `pix_valid_o` is 0 two cycles after any cycle with `scan_en_i`=0.
- R6: A palette entry is 18 bits: red in bits [17:12], green in [11:6], blue in [5:0]. A pixel with index k shows the fields of entry k.
- R7: With `pal_we_i`=1, `pal_sel_i`=0 loads `pal_wdata_i[7:0]` into the entry pointer. `pal_sel_i`=1 writes `pal_wdata_i` into the entry at the pointer and then increments the pointer modulo 256.
- R8: `swap_req_i` raises `swap_pend_o` in the next cycle. The pending swap toggles `front_o` at the edge where the raster wraps, so the next frame is read wholly from the other buffer.
- R9: When the swap takes effect, `swap_pend_o` falls and `swap_done_o` rises. `swap_done_o` stays high until the next `swap_req_i`.
- R10: Writes to the back frame never change the pixels shown from the front frame.
- R11: A request made in the same cycle as the wrap waits for the following wrap. Several requests made before one wrap cause a single toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Pixel write strobe |
| wr_addr_i | input | AW | Linear pixel offset in the back frame |
| wr_data_i | input | 8 | Colour index to store |
| pal_we_i | input | 1 | Palette register write strobe |
| pal_sel_i | input | 1 | 0 selects the entry pointer, 1 selects entry data |
| pal_wdata_i | input | 18 | Pointer value (bits 7:0) or entry colour |
| swap_req_i | input | 1 | Request a front/back exchange |
| scan_en_i | input | 1 | Display pixel enable |
| red_o | output | 6 | Red channel |
| green_o | output | 6 | Green channel |
| blue_o | output | 6 | Blue channel |
| pix_valid_o | output | 1 | Colour channels hold a scanned pixel |
| front_o | output | 1 | Buffer currently displayed |
| swap_pend_o | output | 1 | Swap requested, not yet applied |
| swap_done_o | output | 1 | Last requested swap has been applied |

## Verification
Inputs are driven at the falling edge. The colour for a pixel enabled at one falling edge is compared two falling edges later: it has passed two registers by then, the frame RAM read and then the palette read. The bench holds a queue of the expected colours exactly two entries deep. The swap flags are registered, so they are sampled one falling edge after the request or the wrap. The frame-to-frame checks follow a model of the raster offset, kept from the number of enables issued, and the wrap cycle is taken from that model.

// File: rtl/pal_fb_pkg.sv
package pal_fb_pkg;
  localparam int IDX_W   = 8;
  localparam int PAL_N   = 1 << IDX_W;
  localparam int CH_W    = 6;
  localparam int ENTRY_W = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/pal_fb_ram.sv
module pal_fb_ram #(
  parameter int DEPTH = 160,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           we_i,
  input  logic [AW-1:0]                  waddr_i,
  input  logic [pal_fb_pkg::IDX_W-1:0]   wdata_i,
  input  logic                           re_i,
  input  logic [AW-1:0]                  raddr_i,
  output logic [pal_fb_pkg::IDX_W-1:0]   rdata_o
);
  logic [pal_fb_pkg::IDX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pal_fb_raster.sv
module pal_fb_raster #(
  parameter int DEPTH = 160,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scan_en_i,
  input  logic          swap_req_i,
  output logic [AW-1:0] addr_o,
  output logic          wrap_o,
  output logic          front_o,
  output logic          pend_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic swap_now;

  assign wrap_o   = scan_en_i && (addr_o == LAST);
  assign swap_now = wrap_o && pend_o;   // only an already-latched request counts

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      front_o <= 1'b0;
      pend_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      if (scan_en_i) addr_o <= wrap_o ? '0 : addr_o + 1'b1;
      if (swap_now) front_o <= ~front_o;
      if (swap_req_i)    pend_o <= 1'b1;
      else if (swap_now) pend_o <= 1'b0;
      if (swap_req_i)    done_o <= 1'b0;
      else if (swap_now) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pal_fb_palette.sv
module pal_fb_palette
  import pal_fb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output rgb_t               rgb_o
);
  logic [ENTRY_W-1:0] pal_q [PAL_N];
  logic [IDX_W-1:0]   ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < PAL_N; i++) pal_q[i] <= '0;
    end else if (we_i) begin
      if (!sel_i) begin
        ptr_q <= wdata_i[IDX_W-1:0];
      end else begin
        pal_q[ptr_q] <= wdata_i;
        ptr_q        <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rgb_o <= '0;
    else if (rd_en_i) rgb_o <= rgb_t'(pal_q[rd_idx_i]);
  end
endmodule

// File: rtl/pal_fb_dbuf.sv
module pal_fb_dbuf
  import pal_fb_pkg::*;
#(
  parameter int H_PIX   = 20,
  parameter int V_LINES = 8,
  parameter int FRAME   = H_PIX * V_LINES,
  parameter int AW      = $clog2(FRAME + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [IDX_W-1:0]   wr_data_i,
  input  logic               pal_we_i,
  input  logic               pal_sel_i,
  input  logic [ENTRY_W-1:0] pal_wdata_i,
  input  logic               swap_req_i,
  input  logic               scan_en_i,
  output logic [CH_W-1:0]    red_o,
  output logic [CH_W-1:0]    green_o,
  output logic [CH_W-1:0]    blue_o,
  output logic               pix_valid_o,
  output logic               front_o,
  output logic               swap_pend_o,
  output logic               swap_done_o
);
  localparam int NBUF = 2;

  logic [AW-1:0]    scan_addr;
  logic             wrap;
  logic             wr_ok;
  logic [IDX_W-1:0] rd_data [NBUF];
  logic             rd_buf_q;
  logic             v1_q;
  rgb_t             rgb;

  assign wr_ok = wr_en_i && ({1'b0, wr_addr_i} < (AW+1)'(FRAME));

  pal_fb_raster #(.DEPTH(FRAME), .AW(AW)) u_raster (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scan_en_i (scan_en_i),
    .swap_req_i(swap_req_i),
    .addr_o    (scan_addr),
    .wrap_o    (wrap),
    .front_o   (front_o),
    .pend_o    (swap_pend_o),
    .done_o    (swap_done_o)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    pal_fb_ram #(.DEPTH(FRAME), .AW(AW)) u_ram (
      .clk_i  (clk_i),
      .we_i   (wr_ok && (front_o != 1'(b))),
      .waddr_i(wr_addr_i),
      .wdata_i(wr_data_i),
      .re_i   (scan_en_i && (front_o == 1'(b))),
      .raddr_i(scan_addr),
      .rdata_o(rd_data[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_buf_q    <= 1'b0;
      v1_q        <= 1'b0;
      pix_valid_o <= 1'b0;
    end else begin
      if (scan_en_i) rd_buf_q <= front_o;
      v1_q        <= scan_en_i;
      pix_valid_o <= v1_q;
    end
  end

  pal_fb_palette u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we_i),
    .sel_i   (pal_sel_i),
    .wdata_i (pal_wdata_i),
    .rd_en_i (v1_q),
    .rd_idx_i(rd_data[rd_buf_q]),
    .rgb_o   (rgb)
  );

  assign red_o   = rgb.r;
  assign green_o = rgb.g;
  assign blue_o  = rgb.b;
endmodule

// File: rtl/pal_fb_dbuf_chk.sv
module pal_fb_dbuf_chk #(
  parameter int FRAME = 160,
  parameter int AW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scan_en_i,
  input logic          swap_req_i,
  input logic [AW-1:0] scan_addr,
  input logic          pix_valid_o,
  input logic          front_o,
  input logic          swap_pend_o,
  input logic          swap_done_o
);
  localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

  assert_addr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_addr <= LAST);

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i && scan_addr != LAST |=> scan_addr == $past(scan_addr) + 1'b1);

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> $stable(scan_addr));

  assert_valid_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(scan_en_i, 2));

  assert_req_pend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_req_i |=> swap_pend_o);

  assert_swap_at_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(front_o) |-> $past(swap_pend_o) && $past(scan_en_i) && $past(scan_addr) == LAST);

  assert_done_on_swap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swap_done_o) |-> !$stable(front_o) && !swap_pend_o);
endmodule

bind pal_fb_dbuf pal_fb_dbuf_chk #(.FRAME(FRAME), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scan_en_i  (scan_en_i),
  .swap_req_i (swap_req_i),
  .scan_addr  (scan_addr),
  .pix_valid_o(pix_valid_o),
  .front_o    (front_o),
  .swap_pend_o(swap_pend_o),
  .swap_done_o(swap_done_o)
);

// File: tb/pal_fb_dbuf_test.sv
module pal_fb_dbuf_test;
  localparam int W  = 20;
  localparam int H  = 8;
  localparam int FR = W * H;
  localparam int AW = $clog2(FR + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, pal_we = 0, pal_sel = 0, swap_req = 0, scan_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [17:0]   pal_wdata = '0;
  logic [5:0]    red, green, blue;
  logic          pix_valid, front, pend, done;

  int checks = 0, errors = 0;
  int buf_m [2][FR];
  int pal_m [256];
  int front_m = 0, pend_m = 0, done_m = 0, rpos_m = 0;

  always #2 clk = ~clk;

  pal_fb_dbuf #(.H_PIX(W), .V_LINES(H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pal_we_i(pal_we), .pal_sel_i(pal_sel),
    .pal_wdata_i(pal_wdata), .swap_req_i(swap_req), .scan_en_i(scan_en),
    .red_o(red), .green_o(green), .blue_o(blue), .pix_valid_o(pix_valid),
    .front_o(front), .swap_pend_o(pend), .swap_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ent(input int k);
    return (((k ^ 42) & 63) << 12) | (((k >> 2) & 63) << 6) | ((~k) & 63);
  endfunction

  task automatic flags(input string req);
    chk(front == front_m[0], req, "front_o", front, front_m);
    chk(pend == pend_m[0], req, "swap_pend_o", pend, pend_m);
    chk(done == done_m[0], req, "swap_done_o", done, done_m);
  endtask

  // n enables; swap request pulsed alongside enable number req_at
  task automatic scan(input int n, input int req_at, input string req, input bit zero);
    int q[$];
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int e = q.pop_front();
        chk(pix_valid == 1'b1, req, "pix_valid_o", pix_valid, 1);
        if (zero) e = 0;
        if (e >= 0) chk({red, green, blue} == e[17:0], req, "rgb", {red, green, blue}, e);
      end
      scan_en  = (i < n);
      swap_req = (i == req_at);
      if (i < n) begin
        int v = buf_m[front_m][rpos_m];
        q.push_back(v < 0 ? -1 : pal_m[v]);
        if (rpos_m == FR - 1) begin
          rpos_m = 0;
          if (pend_m != 0) begin front_m ^= 1; pend_m = 0; done_m = 1; end
        end else rpos_m++;
      end
      if (i == req_at) begin pend_m = 1; done_m = 0; end
    end
    scan_en = 0; swap_req = 0;
  endtask

  task automatic pal_write(input bit sel, input int d);
    @(negedge clk); pal_we = 1; pal_sel = sel; pal_wdata = 18'(d);
    @(negedge clk); pal_we = 0;
  endtask

  task automatic px_write(input int a, input int v);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = 8'(v);
    if (a < FR) buf_m[front_m ^ 1][a] = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic request();
    @(negedge clk); swap_req = 1; pend_m = 1; done_m = 0;
    @(negedge clk); swap_req = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    flags("R1");
    chk(pix_valid == 0, "R1", "pix_valid_o", pix_valid, 0);
    chk({red, green, blue} == 0, "R1", "rgb", {red, green, blue}, 0);
    repeat (3) @(negedge clk);
    chk(pix_valid == 0, "R5", "idle valid", pix_valid, 0);
    scan(FR, -1, "R1", 1'b1);
  endtask

  task automatic t_palette();
    pal_write(0, 0);
    for (int k = 0; k < 256; k++) begin pal_write(1, ent(k)); pal_m[k] = ent(k); end
    pal_write(0, 7);
    pal_write(1, 18'h2a5c3); pal_m[7] = 18'h2a5c3;
    pal_write(1, 18'h01f3e); pal_m[8] = 18'h01f3e;
  endtask

  task automatic t_fill(input int mul, input int add);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) px_write(y * W + x, (x * mul + y * 5 + add) & 255);
  endtask

  task automatic t_swap();
    t_fill(3, 1);
    for (int a = FR; a < FR + 4 && a < (1 << AW); a++) px_write(a, 255);  // R3
    request();
    flags("R8");
    scan(FR, -1, "R8", 1'b0);
    @(negedge clk);
    flags("R9");
    scan(FR, -1, "R2 R3 R6 R7", 1'b0);
  endtask

  task automatic t_isolation();
    t_fill(7, 9);
    scan(FR, -1, "R10", 1'b0);
    flags("R10");
  endtask

  task automatic t_latency();
    @(negedge clk); scan_en = 1;
    @(negedge clk); scan_en = 0;
    chk(pix_valid == 0, "R5", "valid at t+1", pix_valid, 0);
    @(negedge clk);
    chk(pix_valid == 1, "R5", "valid at t+2", pix_valid, 1);
    chk({red, green, blue} == pal_m[buf_m[front_m][rpos_m]][17:0], "R5", "rgb at t+2",
        {red, green, blue}, pal_m[buf_m[front_m][rpos_m]]);
    @(negedge clk);
    chk(pix_valid == 0, "R5", "valid at t+3", pix_valid, 0);
    rpos_m++;
    repeat (4) @(negedge clk);
    scan(FR - 1, -1, "R4", 1'b0);
  endtask

  task automatic t_same_cycle();
    scan(FR, FR - 1, "R11", 1'b0);
    @(negedge clk);
    flags("R11");
    scan(FR, -1, "R11", 1'b0);
    @(negedge clk);
    flags("R11");
    scan(FR, -1, "R11", 1'b0);
  endtask

  task automatic t_multi();
    request(); request(); request();
    flags("R11");
    scan(FR, -1, "R11", 1'b0);
    @(negedge clk);
    flags("R11");
    scan(FR, -1, "R11", 1'b0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int a = 0; a < FR; a++) buf_m[b][a] = -1;
    for (int k = 0; k < 256; k++) pal_m[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_palette();
    t_swap();
    t_isolation();
    t_latency();
    t_same_cycle();
    t_multi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule